// File: doc/BRIEF.md
# Configurable GPIO Port with Pull-up Control

This block is one digital I/O port of a chip, with a parameterizable number of pins. Software reaches it through a small register interface with three live addresses: a data register, a direction register and a read-only view of the pins. For each pin the block drives a pad output value, a pad output enable and a pull-up enable. Pad levels come back through a two-flop synchronizer before they can be read. Other peripherals can claim a pin through a per-pin alternate-function input, and a claimed pin loses its pull-up at once.

A parameter picks one of three variants. The bidirectional port has a direction bit and a pull-up choice for each pin. The input-only port never drives its pads, and one control bit turns the pull-ups on for all pins at once. The fixed-output variant works like the bidirectional port, except that one chosen pin is always an output with no pull-up, and its direction bit becomes a high-current drive control. Reset is asynchronous. It releases every pad at once, even when no clock runs.

Top module: `gpio_port_pu`

## Requirements
- R1: While `rst_n` is low, `pad_oe` is all zeros and `hc_drive` is 0. This takes effect as soon as reset asserts, with no clock edge needed.
- R2: In the bidirectional and fixed-output variants, `pad_oe[i]` equals the direction bit and `pad_out[i]` equals the data bit. Both change on the clock edge that takes the register write.
- R3: In the bidirectional variant, `pad_pu[i]` is 1 only when direction bit i is 0, data bit i is 1 and `alt_en[i]` is 0.
- R4: In the input-only variant, `pad_oe` and `pad_out` stay 0. The direction address reads 0 and ignores writes. Data bit 0 is the shared pull-up enable, so `pad_pu[i]` = data[0] AND NOT `alt_en[i]`. Data bits above 0 read 0 and ignore writes.
- R5: In every variant, `pad_pu[i]` is 0 whenever `alt_en[i]` is 1.
- R6: A read of address 0 returns `pad_in` as it was sampled two rising clock edges earlier.
- R7: In the fixed-output variant, pin `HC_PIN` has `pad_oe` = 1 from the first rising edge after reset is released. It never has a pull-up. Direction bit `HC_PIN` reads and writes normally and drives `hc_drive`. In the other variants `hc_drive` is 0.
- R8: Address map: 0 reads the synchronized pins, 1 is the direction register, 2 is the data register, and 3 reads all zeros. Writes to address 0 or address 3 change nothing.
- R9: After reset the data and direction registers read 0, so every pin is an input with no pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr`, combinational |
| pad_in | input | W | Pad levels coming in |
| alt_en | input | W | Per-pin alternate-function claim |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |
| pad_pu | output | W | Pad pull-up enables |
| hc_drive | output | 1 | High-current control for the fixed pin |

## Verification
The assertions check four rules on every cycle. The pads are released whenever reset is low. No pin ever has a pull-up and an output enable together. A claimed pin never has a pull-up. The pin address always returns the pad value from two edges earlier. They also check that a direction write shows up on the enables one edge later, and that the fixed pin stays enabled. The bench's scenarios are needed for the rest. Only they show that reset clears the outputs between clock edges. They also cover the shared pull-up bit of the input-only variant, writes to the pin and reserved addresses being ignored, and the exact data returned at each address under random traffic on all three variants at once.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    // Register addresses
    typedef enum logic [1:0] {
        GP_PIN  = 2'd0,
        GP_DIR  = 2'd1,
        GP_DATA = 2'd2,
        GP_RSVD = 2'd3
    } gp_addr_e;

    // Port variants
    localparam int GP_BIDIR  = 0;
    localparam int GP_INONLY = 1;
    localparam int GP_FIXOUT = 2;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
        end
    end

    assign sync_out = s2_q;
endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int MODE   = GP_BIDIR,
    parameter int HC_PIN = 2
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] alt_en,
    output logic [W-1:0] out_val,
    output logic [W-1:0] pu_val
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (MODE == GP_INONLY) begin : g_in
            // Pads never driven; data bit 0 is the shared pull-up enable
            assign out_val[i] = 1'b0;
            assign pu_val[i]  = data_q[0] & ~alt_en[i];
        end else if (MODE == GP_FIXOUT && i == HC_PIN) begin : g_fix
            assign out_val[i] = data_q[i];
            assign pu_val[i]  = 1'b0;
        end else begin : g_bi
            assign out_val[i] = data_q[i];
            assign pu_val[i]  = ~dir_q[i] & data_q[i] & ~alt_en[i];
        end
    end
endmodule

// File: rtl/gpio_port_pu.sv
`timescale 1ns/1ps
module gpio_port_pu
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int MODE   = GP_BIDIR,
    parameter int HC_PIN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] alt_en,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic         hc_drive
);
    localparam logic [W-1:0] ONES      = {W{1'b1}};
    localparam logic [W-1:0] DATA_MASK = (MODE == GP_INONLY) ? W'(1) : ONES;
    localparam logic [W-1:0] DIR_MASK  = (MODE == GP_INONLY) ? '0 : ONES;
    localparam logic [W-1:0] OE_MASK   = (MODE == GP_INONLY) ? '0 : ONES;
    localparam logic [W-1:0] FIX_MASK  = (MODE == GP_FIXOUT) ? (W'(1) << HC_PIN) : '0;

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] oe;
    } port_st_t;

    port_st_t     st_d, st_q;
    logic [W-1:0] pin_sync;
    gp_addr_e     addr;

    assign addr = gp_addr_e'(bus_addr);

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_pad_ctrl #(.W(W), .MODE(MODE), .HC_PIN(HC_PIN)) u_pad (
        .data_q  (st_q.data),
        .dir_q   (st_q.dir),
        .alt_en  (alt_en),
        .out_val (pad_out),
        .pu_val  (pad_pu)
    );

    // Next-state: register writes and output-enable computation
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (addr)
                GP_DATA: st_d.data = bus_wdata & DATA_MASK;
                GP_DIR:  st_d.dir  = bus_wdata & DIR_MASK;
                default: ;
            endcase
        end
        st_d.oe = (st_d.dir | FIX_MASK) & OE_MASK;
    end

    // All state, including the enables, clears without a clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            GP_PIN:  bus_rdata = pin_sync;
            GP_DIR:  bus_rdata = st_q.dir;
            GP_DATA: bus_rdata = st_q.data;
            default: bus_rdata = '0;
        endcase
    end

    assign pad_oe = st_q.oe;

    if (MODE == GP_FIXOUT) begin : g_hc
        assign hc_drive = st_q.dir[HC_PIN];
    end else begin : g_nohc
        assign hc_drive = 1'b0;
    end
endmodule

// File: rtl/gpio_port_pu_chk.sv
`timescale 1ns/1ps
module gpio_port_pu_chk
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int MODE   = GP_BIDIR,
    parameter int HC_PIN = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] alt_en,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic         hc_drive
);
    localparam logic [W-1:0] FIXM  = (MODE == GP_FIXOUT) ? (W'(1) << HC_PIN) : '0;
    localparam logic [W-1:0] DIRCH = ~FIXM;

    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    // R1
    a_r1_reset_tristate: assert property (@(posedge clk)
        !rst_n |-> (pad_oe == '0 && !hc_drive));

    // R3 and R7: a pin with a pull-up is never driven
    a_r3_pu_only_input: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    a_r5_alt_kills_pu: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & alt_en) == '0);

    a_r6_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && bus_addr == GP_PIN) |-> bus_rdata == $past(pad_in, 2));

    if (MODE != GP_INONLY) begin : g_dir
        a_r2_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == GP_DIR) |=> ((pad_oe & DIRCH) == ($past(bus_wdata) & DIRCH)));
    end else begin : g_in
        a_r4_never_driven: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe == '0);
    end

    if (MODE == GP_FIXOUT) begin : g_fix
        a_r7_fixed_pin_driven: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> pad_oe[HC_PIN]);
    end
endmodule

bind gpio_port_pu gpio_port_pu_chk #(.W(W), .MODE(MODE), .HC_PIN(HC_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .alt_en    (alt_en),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .hc_drive  (hc_drive)
);

// File: tb/sim_gpio_port_pu.sv
`timescale 1ns/1ps
module sim_gpio_port_pu;
    import gpio_pkg::*;

    localparam int W  = 8;
    localparam int HC = 2;
    localparam logic [W-1:0] HCM = W'(1) << HC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]   addr;
    logic         wr;
    logic [W-1:0] wdata, pad_in, alt;
    logic [W-1:0] rd0, out0, oe0, pu0;
    logic [W-1:0] rd1, out1, oe1, pu1;
    logic [W-1:0] rd2, out2, oe2, pu2;
    logic         hc0, hc1, hc2;

    gpio_port_pu #(.W(W), .MODE(GP_BIDIR), .HC_PIN(HC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rd0), .pad_in(pad_in), .alt_en(alt), .pad_out(out0),
        .pad_oe(oe0), .pad_pu(pu0), .hc_drive(hc0));
    gpio_port_pu #(.W(W), .MODE(GP_INONLY), .HC_PIN(HC)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rd1), .pad_in(pad_in), .alt_en(alt), .pad_out(out1),
        .pad_oe(oe1), .pad_pu(pu1), .hc_drive(hc1));
    gpio_port_pu #(.W(W), .MODE(GP_FIXOUT), .HC_PIN(HC)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rd2), .pad_in(pad_in), .alt_en(alt), .pad_out(out2),
        .pad_oe(oe2), .pad_pu(pu2), .hc_drive(hc2));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference: index 0 bidir, 1 input-only, 2 fixed-output
    logic [W-1:0] m_data [3];
    logic [W-1:0] m_dir  [3];
    logic [W-1:0] m_pins [$];
    logic         m_fixon;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_data[k] <= '0;
                m_dir[k]  <= '0;
            end
            m_pins  = '{W'(0), W'(0)};
            m_fixon <= 1'b0;
        end else begin
            m_pins.push_back(pad_in);
            void'(m_pins.pop_front());
            m_fixon <= 1'b1;
            if (wr) begin
                for (int k = 0; k < 3; k++) begin
                    if (addr == 2'd2) m_data[k] <= (k == 1) ? (wdata & W'(1)) : wdata;
                    if (addr == 2'd1 && k != 1) m_dir[k] <= wdata;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] rexp(input int k);
        case (addr)
            2'd0:    return m_pins[0];
            2'd1:    return m_dir[k];
            2'd2:    return m_data[k];
            default: return '0;
        endcase
    endfunction

    task automatic compare_all();
        string rq;
        rq = (addr == 2'd0) ? "R6 pin read" : "R8 register read";
        // bidirectional
        chk("R2 bidir oe", oe0, m_dir[0]);
        chk("R2 bidir out", out0, m_data[0]);
        chk("R3 bidir pull-up", pu0, ~m_dir[0] & m_data[0] & ~alt);
        chk({rq, " bidir"}, rd0, rexp(0));
        chk("R7 hc idle bidir", W'(hc0), '0);
        // input-only
        chk("R4 input-only oe", oe1, '0);
        chk("R4 input-only out", out1, '0);
        chk("R4 R5 shared pull-up", pu1, m_data[1][0] ? ~alt : '0);
        chk({rq, " input-only"}, rd1, rexp(1));
        // fixed-output
        chk("R7 fixed oe", oe2, (m_dir[2] & ~HCM) | (m_fixon ? HCM : '0));
        chk("R2 fixed out", out2, m_data[2]);
        chk("R7 R5 fixed pull-up", pu2, ~m_dir[2] & m_data[2] & ~alt & ~HCM);
        chk("R7 hc drive", W'(hc2), W'(m_dir[2][HC]));
        chk({rq, " fixed"}, rd2, rexp(2));
    endtask

    task automatic drive(input logic w, input logic [1:0] a, input logic [W-1:0] d,
                         input logic [W-1:0] p, input logic [W-1:0] al);
        wr = w; addr = a; wdata = d; pad_in = p; alt = al;
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [W-1:0] d,
                        input logic [W-1:0] p, input logic [W-1:0] al);
        @(negedge clk);
        compare_all();
        drive(w, a, d, p, al);
    endtask

    initial begin
        drive(1'b0, 2'd1, '0, '0, '0);
        m_pins = '{W'(0), W'(0)};
        repeat (2) @(negedge clk);
        // R1 and R9 during reset, before any released edge
        chk("R1 reset oe bidir", oe0, '0);
        chk("R1 reset oe fixed", oe2, '0);
        rst_n = 1'b1;
        // R9: reset values read back
        step(1'b0, 2'd2, '0, 8'hA5, '0);
        step(1'b0, 2'd1, '0, 8'h3C, '0);
        // R2 R3: outputs on low nibble, pull-ups requested on high nibble
        step(1'b1, 2'd1, 8'h0F, 8'h3C, '0);
        step(1'b1, 2'd2, 8'hF5, 8'hC3, '0);
        // R5: claim two pull-up pins
        step(1'b0, 2'd2, '0, 8'hC3, 8'h30);
        // R8: writes to pin and reserved addresses are ignored
        step(1'b1, 2'd0, 8'h00, 8'h81, '0);
        step(1'b1, 2'd3, 8'h00, 8'h81, '0);
        step(1'b0, 2'd3, '0, 8'h81, '0);
        step(1'b0, 2'd2, '0, 8'h81, '0);
        step(1'b0, 2'd1, '0, 8'h81, '0);
        // R7: fixed pin stays driven with its direction bit cleared and set
        step(1'b1, 2'd1, 8'h00, 8'h00, '0);
        step(1'b1, 2'd1, HCM, 8'h00, '0);
        step(1'b0, 2'd0, '0, 8'hFF, '0);
        step(1'b0, 2'd0, '0, 8'h00, '0);

        for (int n = 0; n < 4000; n++) begin
            step(1'($urandom), 2'($urandom), W'($urandom), W'($urandom),
                 ($urandom % 4 == 0) ? W'($urandom) : '0);
            if (n == 2000) begin
                // R1: async reset between edges, checked before any edge
                drive(1'b0, 2'd1, '0, '0, '0);
                #3 rst_n = 1'b0;
                #1;
                chk("R1 async oe bidir", oe0, '0);
                chk("R1 async oe input-only", oe1, '0);
                chk("R1 async oe fixed", oe2, '0);
                chk("R1 async hc", W'(hc2), '0);
                chk("R9 dir cleared", rd0, '0);
                chk("R9 pull-ups off", pu0 | pu2, '0);
                @(negedge clk);
                compare_all();
                rst_n = 1'b1;
            end
        end
        @(negedge clk);
        compare_all();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule